// File: doc/BRIEF.md
# Compartment Access Filter

This block sits between a bus fabric and a set of peripherals. It decides, one request at a time, whether a transaction may reach its target peripheral. Every request presents the target's index, the requester's compartment number, whether the requester is in the secure world, and whether the requester currently holds that peripheral's hardware semaphore. The block answers with a grant or a deny in the same cycle. The semaphores themselves are kept elsewhere and only their held indication is an input here.

The rules come from two kinds of register. Security words hold one bit per peripheral, 32 peripherals to a word. Each peripheral also has its own filter word. That word holds an enable, a semaphore-mode switch, a fixed owner compartment and a whitelist of the compartments that may use the semaphore path. A small memory-mapped port writes and reads these registers. After reset nothing is filtered and every peripheral is open to every compartment.

Top module: `access_filter`

## Requirements
- R1: After reset every register reads 0. Any valid request to an in-range peripheral is then granted, whatever its compartment and security attribute.
- R2: The security bit of peripheral p is bit (p mod 32) of the word at byte offset 0x10 + 4*(p div 32). When that bit is 1, a non-secure request (req_secure=0) is denied and a secure one passes this check. Bits for peripherals beyond the last one are not stored and read as 0.
- R3: The filter word of peripheral p is at byte offset 0x100 + 8*p, with these fields:
  - bit 0: filter enable
  - bit 1: semaphore mode
  - bits 6:4: owner compartment
  - bits 23:16: whitelist, where bit 16+c stands for compartment c

  Only those bits are stored. A write of all ones reads back 0x00FF0073.
- R4: When a peripheral's filter enable is 0, the compartment is not checked and only the security check of R2 applies.
- R5: When filter enable is 1, semaphore mode is 0 and the owner is 0, every compartment passes the compartment check.
- R6: When filter enable is 1, semaphore mode is 0 and the owner is nonzero, a request passes the compartment check only if its compartment equals the owner.
- R7: When filter enable and semaphore mode are both 1, the owner field is ignored. A request passes only if the whitelist bit of its compartment is 1 and req_sem_held is 1.
- R8: A request whose index is NUM_PERIPH or higher is denied.
- R9: grant and deny follow the request and register contents combinationally. A register write becomes visible in both the read data and the decision on the cycle after the write edge.
- R10: Reads of any offset not covered by R2 or R3 return 0, and this includes misaligned offsets. Writes to such offsets change no register.
- R11: deny is 1 exactly when req_valid is 1 and grant is 0. When req_valid is 0, both grant and deny are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable, whole 32-bit word |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| req_valid | input | 1 | A request is present |
| req_idx | input | IDX_W | Target peripheral index |
| req_cid | input | 3 | Requester compartment number |
| req_secure | input | 1 | Requester is secure |
| req_sem_held | input | 1 | Requester holds the target's semaphore |
| grant | output | 1 | Request may proceed |
| deny | output | 1 | Request is blocked |

## Verification
The decision path is purely combinational, so a corrupted filter word or security bit changes grant on the first request that selects that peripheral. The same fault shows on reg_rdata as soon as the word's offset is read. A write that lands on the wrong entry, or that keeps bits it should drop, therefore appears within one cycle of the next read or request that touches either entry. Because of this, the bench runs mixed writes, reads and requests every cycle and compares every output on every cycle.

// File: rtl/afilt_pkg.sv
package afilt_pkg;

  localparam int CID_W      = 3;
  localparam int NUM_CID    = 1 << CID_W;
  localparam int SEC_BASE   = 'h10;
  localparam int CFG_BASE   = 'h100;
  localparam int CFG_STRIDE = 8;

  typedef struct packed {
    logic [NUM_CID-1:0] wl;
    logic [CID_W-1:0]   owner;
    logic               semen;
    logic               fen;
  } afilt_cfg_t;

  function automatic logic [31:0] cfg_to_word(input afilt_cfg_t c);
    logic [31:0] w;
    w        = '0;
    w[0]     = c.fen;
    w[1]     = c.semen;
    w[6:4]   = c.owner;
    w[23:16] = c.wl;
    return w;
  endfunction

  function automatic afilt_cfg_t word_to_cfg(input logic [31:0] w);
    afilt_cfg_t c;
    c.fen   = w[0];
    c.semen = w[1];
    c.owner = w[6:4];
    c.wl    = w[23:16];
    return c;
  endfunction

endpackage

// File: rtl/afilt_sec_bank.sv
module afilt_sec_bank #(
  parameter int NUM_PERIPH = 40,
  parameter int IDX_W      = 8,
  parameter int SEL_W      = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] sel,
  input  logic [31:0]      wdata,
  output logic [31:0]      rd_data,
  input  logic [IDX_W-1:0] req_idx,
  output logic             sec_bit
);

  localparam int NSEC      = (NUM_PERIPH + 31) / 32;
  localparam int LAST_BITS = NUM_PERIPH - 32 * (NSEC - 1);

  logic [31:0]     word_q [NSEC];
  logic [31:0]     word_d [NSEC];
  logic [NSEC-1:0] word_en;

  for (genvar w = 0; w < NSEC; w++) begin : g_word
    localparam logic [31:0] KEEP = (w < NSEC - 1) ? 32'hFFFF_FFFF
                                                  : 32'((64'd1 << LAST_BITS) - 64'd1);

    assign word_en[w] = wr_en && (sel == SEL_W'(w));

    always_comb begin
      word_d[w] = wdata & KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[w] <= '0;
      end else if (word_en[w]) begin
        word_q[w] <= word_d[w];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int w = 0; w < NSEC; w++) begin
      if (sel == SEL_W'(w)) rd_data = word_q[w];
    end
  end

  always_comb begin
    sec_bit = 1'b0;
    for (int w = 0; w < NSEC; w++) begin
      if ((req_idx >> 5) == IDX_W'(w)) sec_bit = word_q[w][req_idx[4:0]];
    end
  end

endmodule

// File: rtl/afilt_cfg_bank.sv
module afilt_cfg_bank import afilt_pkg::*; #(
  parameter int NUM_PERIPH = 40,
  parameter int IDX_W      = 8,
  parameter int SEL_W      = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] sel,
  input  afilt_cfg_t       wcfg,
  output afilt_cfg_t       rd_cfg,
  input  logic [IDX_W-1:0] req_idx,
  output afilt_cfg_t       req_cfg
);

  afilt_cfg_t            cfg_q [NUM_PERIPH];
  afilt_cfg_t            cfg_d [NUM_PERIPH];
  logic [NUM_PERIPH-1:0] cfg_en;

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_ent
    assign cfg_en[i] = wr_en && (sel == SEL_W'(i));

    always_comb begin
      cfg_d[i] = wcfg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[i] <= '0;
      end else if (cfg_en[i]) begin
        cfg_q[i] <= cfg_d[i];
      end
    end
  end

  always_comb begin
    rd_cfg = '0;
    for (int i = 0; i < NUM_PERIPH; i++) begin
      if (sel == SEL_W'(i)) rd_cfg = cfg_q[i];
    end
  end

  always_comb begin
    req_cfg = '0;
    for (int i = 0; i < NUM_PERIPH; i++) begin
      if (req_idx == IDX_W'(i)) req_cfg = cfg_q[i];
    end
  end

endmodule

// File: rtl/afilt_decide.sv
module afilt_decide import afilt_pkg::*; (
  input  logic             req_valid,
  input  logic             in_range,
  input  logic             sec_bit,
  input  afilt_cfg_t       cfg,
  input  logic [CID_W-1:0] cid,
  input  logic             secure,
  input  logic             held,
  output logic             grant,
  output logic             deny
);

  logic sec_ok;
  logic id_ok;

  always_comb begin
    sec_ok = !sec_bit || secure;
    if (!cfg.fen) begin
      id_ok = 1'b1;
    end else if (cfg.semen) begin
      id_ok = cfg.wl[cid] && held;
    end else begin
      id_ok = (cfg.owner == '0) || (cfg.owner == cid);
    end
    grant = req_valid && in_range && sec_ok && id_ok;
    deny  = req_valid && !grant;
  end

endmodule

// File: rtl/access_filter.sv
module access_filter import afilt_pkg::*; #(
  parameter int NUM_PERIPH = 40,
  parameter int IDX_W      = 8,
  parameter int ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [CID_W-1:0]  req_cid,
  input  logic              req_secure,
  input  logic              req_sem_held,
  output logic              grant,
  output logic              deny
);

  localparam int NSEC = (NUM_PERIPH + 31) / 32;
  localparam logic [ADDR_W-1:0] SEC_LO = ADDR_W'(SEC_BASE);
  localparam logic [ADDR_W-1:0] SEC_HI = ADDR_W'(SEC_BASE + 4 * NSEC);
  localparam logic [ADDR_W-1:0] CFG_LO = ADDR_W'(CFG_BASE);
  localparam logic [ADDR_W-1:0] CFG_HI = ADDR_W'(CFG_BASE + CFG_STRIDE * NUM_PERIPH);

  logic [ADDR_W-1:0] sec_off, cfg_off, sec_sel, cfg_sel;
  logic              sec_hit, cfg_hit;
  logic [31:0]       sec_rd;
  afilt_cfg_t        cfg_rd;
  afilt_cfg_t        cfg_req;
  logic              sec_req_bit;
  logic              in_range;

  // register port decode
  always_comb begin
    sec_off = reg_addr - SEC_LO;
    cfg_off = reg_addr - CFG_LO;
    sec_hit = (reg_addr >= SEC_LO) && (reg_addr < SEC_HI) && (sec_off[1:0] == 2'b00);
    cfg_hit = (reg_addr >= CFG_LO) && (reg_addr < CFG_HI) && (cfg_off[2:0] == 3'b000);
    sec_sel = sec_hit ? {2'b00, sec_off[ADDR_W-1:2]} : '1;
    cfg_sel = cfg_hit ? {3'b000, cfg_off[ADDR_W-1:3]} : '1;
  end

  afilt_sec_bank #(
    .NUM_PERIPH (NUM_PERIPH),
    .IDX_W      (IDX_W),
    .SEL_W      (ADDR_W)
  ) u_sec_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_we && sec_hit),
    .sel     (sec_sel),
    .wdata   (reg_wdata),
    .rd_data (sec_rd),
    .req_idx (req_idx),
    .sec_bit (sec_req_bit)
  );

  afilt_cfg_bank #(
    .NUM_PERIPH (NUM_PERIPH),
    .IDX_W      (IDX_W),
    .SEL_W      (ADDR_W)
  ) u_cfg_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_we && cfg_hit),
    .sel     (cfg_sel),
    .wcfg    (word_to_cfg(reg_wdata)),
    .rd_cfg  (cfg_rd),
    .req_idx (req_idx),
    .req_cfg (cfg_req)
  );

  always_comb begin
    if (sec_hit)      reg_rdata = sec_rd;
    else if (cfg_hit) reg_rdata = cfg_to_word(cfg_rd);
    else              reg_rdata = '0;
  end

  assign in_range = {1'b0, req_idx} < (IDX_W + 1)'(NUM_PERIPH);

  afilt_decide u_decide (
    .req_valid (req_valid),
    .in_range  (in_range),
    .sec_bit   (sec_req_bit),
    .cfg       (cfg_req),
    .cid       (req_cid),
    .secure    (req_secure),
    .held      (req_sem_held),
    .grant     (grant),
    .deny      (deny)
  );

endmodule

// File: rtl/afilt_checker.sv
module afilt_checker import afilt_pkg::*; #(
  parameter int NUM_PERIPH = 40,
  parameter int IDX_W      = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [IDX_W-1:0] req_idx,
  input logic [CID_W-1:0] req_cid,
  input logic             req_secure,
  input logic             req_sem_held,
  input logic             grant,
  input logic             deny,
  input logic             sec_bit,
  input afilt_cfg_t       cfg
);

  a_r8_out_of_range_denied: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ({1'b0, req_idx} >= (IDX_W + 1)'(NUM_PERIPH))) |-> !grant);

  a_r2_secure_only: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !req_secure) |-> !sec_bit);

  a_r6_owner_match: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && cfg.fen && !cfg.semen && (cfg.owner != '0)) |-> (cfg.owner == req_cid));

  a_r7_semaphore_path: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && cfg.fen && cfg.semen) |-> (req_sem_held && cfg.wl[req_cid]));

  a_r11_grant_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (grant || deny) |-> req_valid);

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && deny));

endmodule

bind access_filter afilt_checker #(
  .NUM_PERIPH (NUM_PERIPH),
  .IDX_W      (IDX_W)
) u_afilt_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_idx      (req_idx),
  .req_cid      (req_cid),
  .req_secure   (req_secure),
  .req_sem_held (req_sem_held),
  .grant        (grant),
  .deny         (deny),
  .sec_bit      (sec_req_bit),
  .cfg          (cfg_req)
);

// File: tb/access_filter_bench.sv
module access_filter_bench;

  localparam int N = 40;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        req_valid;
  logic [7:0]  req_idx;
  logic [2:0]  req_cid;
  logic        req_secure;
  logic        req_sem_held;
  logic        grant;
  logic        deny;

  int vectors = 0;
  int fails   = 0;

  logic [31:0] m_sec [2];
  logic [31:0] m_cfg [N];

  always #5 clk = ~clk;

  access_filter u_access_filter (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_idx(req_idx), .req_cid(req_cid), .req_secure(req_secure),
    .req_sem_held(req_sem_held), .grant(grant), .deny(deny)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h (t=%0t)", tag, got, exp, $time);
    end
  endtask

  function automatic logic model_grant(input logic v, input int idx, input int cid,
                                       input logic s, input logic h, output string tag);
    logic [31:0] c;
    logic        ok;
    if (!v) begin tag = "R11"; return 1'b0; end
    if (idx >= N) begin tag = "R8"; return 1'b0; end
    c = m_cfg[idx];
    if (!c[0])         begin tag = "R4"; ok = 1'b1; end
    else if (c[1])     begin tag = "R7"; ok = c[16 + cid] && h; end
    else if (c[6:4] == 0) begin tag = "R5"; ok = 1'b1; end
    else               begin tag = "R6"; ok = (int'(c[6:4]) == cid); end
    if (m_sec[idx / 32][idx % 32] && !s) begin tag = "R2"; return 1'b0; end
    return ok;
  endfunction

  function automatic logic [31:0] model_rd(input int a, output string tag);
    if (a >= 'h10 && a < 'h18 && a % 4 == 0) begin tag = "R2"; return m_sec[(a - 'h10) / 4]; end
    if (a >= 'h100 && a < 'h100 + 8 * N && a % 8 == 0) begin tag = "R3"; return m_cfg[(a - 'h100) / 8]; end
    tag = "R10";
    return 32'h0;
  endfunction

  function automatic void model_wr(input int a, input logic [31:0] d);
    if (a >= 'h10 && a < 'h18 && a % 4 == 0)
      m_sec[(a - 'h10) / 4] = (a == 'h14) ? (d & ((32'd1 << (N - 32)) - 1)) : d;
    else if (a >= 'h100 && a < 'h100 + 8 * N && a % 8 == 0)
      m_cfg[(a - 'h100) / 8] = d & 32'h00FF_0073;
  endfunction

  task automatic step(input logic we, input int a, input logic [31:0] wd,
                      input logic v, input int idx, input int cid,
                      input logic s, input logic h, input string ftag);
    string gt, rt;
    logic  eg;
    logic [31:0] er;
    @(negedge clk);
    reg_we = we; reg_addr = 12'(a); reg_wdata = wd;
    req_valid = v; req_idx = 8'(idx); req_cid = 3'(cid);
    req_secure = s; req_sem_held = h;
    #1;
    eg = model_grant(v, idx, cid, s, h, gt);
    if (ftag != "") gt = ftag;
    chk({gt, " grant"}, {31'b0, grant}, {31'b0, eg});
    chk("R11 deny", {31'b0, deny}, {31'b0, v && !eg});
    er = model_rd(a, rt);
    chk({rt, " rdata"}, reg_rdata, er);
    if (we) model_wr(a, wd);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL R1..: watchdog expired, got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    foreach (m_sec[i]) m_sec[i] = '0;
    foreach (m_cfg[i]) m_cfg[i] = '0;
    rst_n = 1'b0; reg_we = 0; reg_addr = 12'h100; reg_wdata = 0;
    req_valid = 0; req_idx = 0; req_cid = 0; req_secure = 0; req_sem_held = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 rdata in reset", reg_rdata, 32'h0);
    rst_n = 1'b1;

    // R1: reset state
    step(0, 'h10, 0, 1, 5, 3, 0, 0, "R1");
    step(0, 'h128, 0, 1, 37, 6, 0, 1, "R1");
    // R9: write and request the same cycle sees the old value
    step(1, 'h10, 32'h20, 1, 5, 3, 0, 0, "R9");
    step(0, 'h10, 0, 1, 5, 3, 0, 0, "R2");
    step(0, 'h10, 0, 1, 5, 3, 1, 0, "R2");
    // R6 owner
    step(1, 'h138, 32'h21, 1, 7, 3, 0, 0, "R9");
    step(0, 'h138, 0, 1, 7, 2, 0, 0, "R6");
    step(0, 'h138, 0, 1, 7, 3, 0, 0, "R6");
    // R5 owner zero
    step(1, 'h138, 32'h01, 1, 7, 6, 0, 0, "");
    step(0, 'h138, 0, 1, 7, 6, 0, 0, "R5");
    // R7 semaphore mode
    step(1, 'h138, 32'h0010_0023, 0, 0, 0, 0, 0, "");
    step(0, 'h138, 0, 1, 7, 2, 0, 1, "R7");
    step(0, 'h138, 0, 1, 7, 4, 0, 1, "R7");
    step(0, 'h138, 0, 1, 7, 4, 0, 0, "R7");
    // R3 field mask
    step(1, 'h148, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, "");
    step(0, 'h148, 0, 0, 0, 0, 0, 0, "R3");
    // R2 last-word mask, R8 range
    step(1, 'h14, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, "");
    step(0, 'h14, 0, 1, 40, 0, 1, 0, "R8");
    step(0, 'h14, 0, 1, 39, 0, 1, 0, "R2");
    step(0, 'h14, 0, 1, 39, 0, 0, 0, "R2");
    step(0, 'h10, 0, 1, 200, 0, 1, 0, "R8");
    // R10 unmapped
    step(1, 'h104, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, "");
    step(1, 'h18, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, "");
    step(1, 'h0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, "");
    step(0, 'h104, 0, 1, 0, 5, 0, 0, "R10");
    step(0, 'h18, 0, 0, 0, 0, 0, 0, "R10");
    step(0, 'h100, 0, 0, 3, 0, 0, 0, "R11");

    // mixed traffic
    for (int n = 0; n < 3000; n++) begin
      int sel, a;
      logic [31:0] d;
      sel = $urandom % 8;
      case (sel)
        0: a = 'h10;
        1: a = 'h14;
        2: a = 'h18;
        4: a = 'h100 + 8 * ($urandom % 44) + 4;
        5: a = $urandom % 4096;
        default: a = 'h100 + 8 * ($urandom % 44);
      endcase
      d = $urandom;
      step(($urandom % 4) == 0, a, d, ($urandom % 8) != 0, $urandom % 46,
           $urandom % 8, $urandom % 2, $urandom % 2, "");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule